// File: doc/BRIEF.md
# Randomized Core Clock Enable Generator

This block sits between the external card clock and the processor core. It runs on the external clock, and each cycle it decides whether the core may take a step. The decision is random and gives one core step per four external cycles on average. An observer timing the supply current therefore cannot line up core activity with the external clock. The random bits come from a one-bit raw noise input. That input is whitened by a 16-bit maximal-length shift register before any bit is used. Peripherals that must keep exact time, such as a serial port or a timer, get a separate enable that is never gated.

On every external cycle the core skips, the block raises a dummy-activity request and drives a random byte for the core's bus logic to place on an unused bus slot. The power drawn in a skipped cycle then resembles the power drawn in a real one. Two outputs expose statistics. A window counter reports how many core steps occurred in each block of 1000 external cycles, with a one-cycle pulse each time a window closes. A bench uses them to confirm the rate.

Top module: `rand_clk_gate`

## Requirements
- R1: Each external cycle out of reset, the 16-bit whitening register advances two shift steps. A step shifts the register left by one and inserts at bit 0 the XOR of bits 15, 13, 12 and 10. In the first step only, the noise input is also XORed into the inserted bit. After both steps, bit 1 holds the first inserted bit and bit 0 holds the second.
- R2: While reset is low, the whitening register loads the seed 16'hACE1. If two shift steps would leave the register all zero, it loads the seed instead.
- R3: Outside reset, `core_en` is 1 exactly when bits 1 and 0 of the whitening register are both 1.
- R4: `periph_en` is 1 in every cycle, including the cycles when reset is low.
- R5: Outside reset, `dummy_req` is the inverse of `core_en`. While reset is low, both `core_en` and `dummy_req` are 0.
- R6: `dummy_data` equals bits 15 down to 8 of the whitening register when `dummy_req` is 1, and is 0 otherwise.
- R7: Every 1000th external cycle after reset, `win_done` is 1 for one cycle. From that point `win_count` holds the number of cycles in the window just closed that had `core_en` at 1, and keeps that value until the next window closes. Both are 0 after reset, until the first window closes.
- R8: Each window's core-step count lies between 200 and 300, and the mean over many windows is close to 250.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External card clock |
| rst_n | input | 1 | Synchronous reset, active low |
| noise_i | input | 1 | Raw noise bit, sampled every cycle |
| core_en | output | 1 | Clock enable for the randomized core |
| periph_en | output | 1 | Ungated enable for timing-critical peripherals |
| dummy_req | output | 1 | Request for dummy bus activity in a skipped cycle |
| dummy_data | output | 8 | Random byte to drive during dummy activity |
| win_count | output | 10 | Core steps counted in the last completed window |
| win_done | output | 1 | One-cycle pulse when a window closes |

## Verification
The assertions check, on every cycle, that the register shifts by two positions, that it never reaches zero, that it reloads the seed under reset, and that the core enable and the dummy request are never both high. They also check that the dummy byte is zero when no request is raised, that the window count never exceeds the number of cycles elapsed, and that the close pulse lasts a single cycle. Only the bench can show that the exact bit sequence follows the tap set and the noise injection under all-zero, all-one and random noise. Only the bench can show that the seed reappears after a second reset, and that the windowed counts stay inside the 200 to 300 band with a mean near one quarter.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;   // bits 15, 13, 12, 10
    localparam int          DATA_W    = 8;

    typedef logic [LFSR_W-1:0] lfsr_t;

    // One Fibonacci step with an optional injected bit.
    function automatic lfsr_t lfsr_step(input lfsr_t s, input logic inj);
        return {s[LFSR_W-2:0], (^(s & LFSR_TAPS)) ^ inj};
    endfunction

    typedef struct packed {
        lfsr_t state;
    } whiten_regs_t;

endpackage

// File: rtl/rcg_whitener.sv
module rcg_whitener
    import rcg_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  noise_i,
    output lfsr_t state_o
);

    localparam lfsr_t EFF_SEED = (SEED == '0) ? lfsr_t'(1) : SEED;

    whiten_regs_t r_d, r_q;
    lfsr_t        step1, step2;

    always_comb begin
        step1 = lfsr_step(r_q.state, noise_i);
        step2 = lfsr_step(step1, 1'b0);
        r_d   = r_q;
        if (!rst_n) begin
            r_d.state = EFF_SEED;
        end else if (step2 == '0) begin
            r_d.state = EFF_SEED;
        end else begin
            r_d.state = step2;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_o = r_q.state;

    // R1: two-position shift between consecutive active cycles
    p_shift_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((r_q.state[LFSR_W-1:2] == $past(r_q.state[LFSR_W-3:0]))
                          || (r_q.state == EFF_SEED)));

    // R2: register never sits at zero once running
    p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (r_q.state != '0));

    // R2: reset loads the seed
    p_seed_r2: assert property (@(posedge clk)
        !rst_n |=> (r_q.state == EFF_SEED));

endmodule

// File: rtl/rcg_window.sv
module rcg_window #(
    parameter int WINDOW = 1000,
    parameter int CW     = $clog2(WINDOW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    output logic [CW-1:0] count_o,
    output logic          done_o
);

    localparam int PW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(WINDOW - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [CW-1:0] acc;
        logic [CW-1:0] last;
        logic          done;
    } win_regs_t;

    win_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!rst_n) begin
            r_d = '0;
        end else if (r_q.pos == LAST_POS) begin
            r_d.last = r_q.acc + CW'(hit_i);
            r_d.acc  = '0;
            r_d.pos  = '0;
            r_d.done = 1'b1;
        end else begin
            r_d.pos = r_q.pos + 1'b1;
            r_d.acc = r_q.acc + CW'(hit_i);
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign count_o = r_q.last;
    assign done_o  = r_q.done;

    // R7: accumulated hits never exceed the cycles elapsed in the window
    p_acc_le_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(r_q.acc) <= CW'(r_q.pos));

    // R7: close pulse lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: reported count bounded by window length
    p_count_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(WINDOW));

endmodule

// File: rtl/rand_clk_gate.sv
module rand_clk_gate
    import rcg_pkg::*;
#(
    parameter logic [15:0] SEED   = 16'hACE1,
    parameter int          WINDOW = 1000,
    parameter int          CW     = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              noise_i,
    output logic              core_en,
    output logic              periph_en,
    output logic              dummy_req,
    output logic [DATA_W-1:0] dummy_data,
    output logic [CW-1:0]     win_count,
    output logic              win_done
);

    lfsr_t state;
    logic  hit;

    rcg_whitener #(.SEED(SEED)) u_whiten (
        .clk     (clk),
        .rst_n   (rst_n),
        .noise_i (noise_i),
        .state_o (state)
    );

    always_comb begin
        hit        = rst_n & state[1] & state[0];
        core_en    = hit;
        periph_en  = 1'b1;
        dummy_req  = rst_n & ~hit;
        dummy_data = dummy_req ? state[LFSR_W-1 -: DATA_W] : '0;
    end

    rcg_window #(.WINDOW(WINDOW), .CW(CW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .count_o (win_count),
        .done_o  (win_done)
    );

    // R5: exactly one of core step or dummy activity in each active cycle
    p_one_activity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({core_en, dummy_req}));

    // R6: no random byte leaks when no dummy request is raised
    p_data_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dummy_req |-> (dummy_data == '0));

endmodule

// File: tb/test_rand_clk_gate.sv
module test_rand_clk_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       noise_i = 1'b0;
    logic       core_en, periph_en, dummy_req, win_done;
    logic [7:0] dummy_data;
    logic [9:0] win_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    rand_clk_gate i_rand_clk_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .noise_i    (noise_i),
        .core_en    (core_en),
        .periph_en  (periph_en),
        .dummy_req  (dummy_req),
        .dummy_data (dummy_data),
        .win_count  (win_count),
        .win_done   (win_done)
    );

    // Behavioural reference
    logic [15:0] m_reg;
    int          m_pos, m_acc, m_last;
    bit          m_done;
    int          win_hist[$];

    function automatic logic [15:0] adv(input logic [15:0] s, input logic n);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10] ^ n;
        return {s[14:0], fb};
    endfunction

    always @(posedge clk) begin
        logic [15:0] nx;
        bit hit_m;
        hit_m = (m_reg[1:0] == 2'b11);
        if (!rst_n) begin
            m_reg = 16'hACE1;
            m_pos = 0; m_acc = 0; m_last = 0; m_done = 0;
        end else begin
            nx = adv(adv(m_reg, noise_i), 1'b0);
            m_reg = (nx == 16'h0) ? 16'hACE1 : nx;
            if (m_pos == 999) begin
                m_last = m_acc + int'(hit_m);
                m_acc = 0; m_pos = 0; m_done = 1;
            end else begin
                m_pos++; m_acc += int'(hit_m); m_done = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit e_core, e_req;
        logic [7:0] e_data;
        if (m_reg !== 16'hx) begin
            e_core = rst_n && (m_reg[1:0] == 2'b11);
            e_req  = rst_n && !e_core;
            e_data = e_req ? m_reg[15:8] : 8'h00;
            chk(core_en === e_core, "R3 R1 core_en", int'(core_en), int'(e_core));
            chk(dummy_req === e_req, "R5 dummy_req", int'(dummy_req), int'(e_req));
            chk(dummy_data === e_data, "R6 R1 dummy_data", int'(dummy_data), int'(e_data));
            chk(periph_en === 1'b1, "R4 periph_en", int'(periph_en), 1);
            chk(win_done === m_done, "R7 win_done", int'(win_done), int'(m_done));
            chk(int'(win_count) == m_last, "R7 win_count", int'(win_count), m_last);
            if (rst_n && m_done) win_hist.push_back(m_last);
        end
    end

    task automatic run(input int n, input int mode, inout int unsigned lcg);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            case (mode)
                0: noise_i = 1'b0;
                1: noise_i = 1'b1;
                default: begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    noise_i = lcg[27];
                end
            endcase
        end
    endtask

    task automatic reset_seq;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(core_en === 1'b0 && dummy_req === 1'b0, "R5 reset quiet",
            int'({core_en, dummy_req}), 0);
        chk(win_count === 10'd0 && win_done === 1'b0, "R7 reset count",
            int'(win_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dummy_data === 8'hAC && core_en === 1'b0, "R2 seed after reset",
            int'(dummy_data), 8'hAC);
    endtask

    initial begin
        int unsigned lcg = 32'h1234_5678;
        int sum;
        reset_seq();
        run(3000, 0, lcg);          // noise held low
        run(3000, 1, lcg);          // noise held high
        reset_seq();                // second reset reloads seed
        win_hist.delete();
        run(20500, 2, lcg);         // random noise
        @(negedge clk);
        chk(win_hist.size() >= 20, "R8 window count", win_hist.size(), 20);
        sum = 0;
        foreach (win_hist[k]) begin
            sum += win_hist[k];
            chk(win_hist[k] >= 200 && win_hist[k] <= 300, "R8 window band",
                win_hist[k], 250);
        end
        if (win_hist.size() > 0)
            chk((sum / win_hist.size()) >= 235 && (sum / win_hist.size()) <= 265,
                "R8 mean rate", sum / win_hist.size(), 250);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule